// File: doc/BRIEF.md
# Root Hub Port Status and Control

This block holds the root-hub state of a host controller with two downstream ports. Each port has one status/control word. The low bytes report connect, enable, suspend, reset-in-progress and power. A middle byte holds sticky change flags. Software does not write port state directly. It writes command bits: reset, enable, disable, suspend, resume, power on and power off. Each command is carried out only when the port's present state allows it. A command that needs a device on a port with nothing attached raises the connect-change flag instead of acting.

Power is switched in one of several ways, chosen by a mode field in a hub descriptor word. A per-port mask in a second descriptor word decides which ports follow the global power commands and which accept their own. A per-port device-presence input drives the connect bit. A slow tick input paces the port reset. Software reaches all of this through a 32-bit word-addressed register bus with byte enables. Each byte lane is decoded on its own.

Top module: `rh_port_block`

## Requirements
- R1: After reset, both port words and the hub status word read 0. The descriptor-A word (word 1) reads 0x00000002: the port count is in bits 7:0 and the power mode in bits 9:8 is 0.
- R2: When `dev_present[i]` changes, the edge that samples the new level copies it into connect status (bit 0) and sets connect-change (bit 16). A removal also clears enable, suspend and in-reset.
- R3: Writing bit 4 to a connected port sets in-reset (bit 4). On the edge that samples the RESET_TICKS-th `reset_tick` pulse after that write, bit 4 clears and reset-complete change (bit 20) sets. No `reset_tick` pulses means no completion.
- R4: Writing bit 0, 1 or 4 to a port whose connect status is 0 sets only bit 16 and changes no other state.
- R5: On a connected port, writing bit 1 sets enable (bit 1) and writing bit 0 clears it. When both bits are written together, the port ends up disabled.
- R6: Writing bit 2 sets suspend (bit 2) and writing bit 3 clears it. When both are written together, suspend ends up set. Suspend-change (bit 18) sets only when a write takes suspend from 1 to 0.
- R7: Byte 2 of a port word is write-one-to-clear over bits 20:16. Byte 3 ignores writes.
- R8: The hub status word is word 3. In power mode 0, writing bit 16 of it powers every port (bit 8). In the same mode, writing bit 0 removes power from every port and clears its bits 0, 1, 2 and 4 and bits 16, 17, 18 and 20.
- R9: Power mode 1 is written to bits 9:8 of word 1. In that mode the global power commands act only on ports whose mask bit is clear; the mask bit for port i is bit 17+i of word 2. Writing bit 8 of a port word powers it and writing bit 9 unpowers it, but only in mode 1 and only on ports whose mask bit is set.
- R10: Writing byte 0 of word 2 with bit 1+i clear marks port i connected. If the port was not connected, its bit 16 sets as well.
- R11: Writing bits 7:6 of word 0 as 00 loads the change byte of both ports with 0x16. Any other value leaves the ports untouched.
- R12: Writing bit 15 of the hub status word sets status bit 15. Writing bit 31 clears it.
- R13: Writing word 1 with bit 9 set powers every port at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word index of the write |
| bus_be | input | 4 | Byte enables of the write |
| bus_wdata | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word index of the read |
| rd_data | output | 32 | Read data, combinational from registers |
| reset_tick | input | 1 | Pacing pulse for port reset timing |
| dev_present | input | NPORTS | Device attached, one bit per port |

## Verification
Every register write takes effect on the clock edge that samples the strobe. The read path is combinational. So the bench drives each write on a falling edge, removes it on the next falling edge, and reads the result straight after that. A change of `dev_present` is due one edge after it is applied, and it is checked at the same point. Reset completion is due at the edge that samples the final tick pulse. The bench checks in-reset still set after one pulse fewer, then clears the flag after the last pulse.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int unsigned WORD_CTRL  = 0;
  localparam int unsigned WORD_DESCA = 1;
  localparam int unsigned WORD_DESCB = 2;
  localparam int unsigned WORD_HUB   = 3;
  localparam int unsigned WORD_PORT0 = 4;

  // chg[0] connect, [1] enable, [2] suspend, [3] spare, [4] reset done
  typedef struct packed {
    logic [4:0] chg;
    logic       pwr;
    logic       rst_act;
    logic       susp;
    logic       ena;
    logic       conn;
  } port_state_t;

  function automatic logic [31:0] pack_port(port_state_t s);
    return {11'b0, s.chg, 7'b0, s.pwr, 3'b0, s.rst_act, 1'b0, s.susp, s.ena, s.conn};
  endfunction
endpackage

// File: rtl/rh_reset_timer.sv
module rh_reset_timer #(
  parameter int unsigned RESET_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic keep,
  input  logic tick,
  output logic expire,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(RESET_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy   = (cnt_q != '0);
  assign expire = tick && (cnt_q == CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!keep)
      cnt_d = '0;
    else if (start)
      cnt_d = CNT_W'(RESET_TICKS);
    else if (tick && busy)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rh_port_unit.sv
module rh_port_unit
  import rh_pkg::*;
#(
  parameter int unsigned RESET_TICKS = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dev_present,
  input  logic        tick,
  input  logic        wr_sel,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  input  logic        glb_on,
  input  logic        glb_off,
  input  logic        bus_rst,
  input  logic        mark_conn,
  input  logic        pwr_ok,
  output port_state_t st
);
  port_state_t st_q, st_d;
  logic        pres_q;
  logic        start, tmr_expire, tmr_busy;
  logic        wb0, wb1, wb2;

  assign wb0 = wr_sel && be[0];
  assign wb1 = wr_sel && be[1] && pwr_ok;
  assign wb2 = wr_sel && be[2];
  assign st  = st_q;

  rh_reset_timer #(.RESET_TICKS(RESET_TICKS)) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .keep   (st_d.rst_act),
    .tick   (tick),
    .expire (tmr_expire),
    .busy   (tmr_busy)
  );

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    if (tmr_expire) begin
      st_d.rst_act = 1'b0;
      st_d.chg[4]  = 1'b1;
    end
    if (pres_q != dev_present) begin
      st_d.conn   = dev_present;
      st_d.chg[0] = 1'b1;
      if (!dev_present) begin
        st_d.ena     = 1'b0;
        st_d.susp    = 1'b0;
        st_d.rst_act = 1'b0;
      end
    end
    if (glb_off) begin
      st_d.pwr     = 1'b0;
      st_d.conn    = 1'b0;
      st_d.ena     = 1'b0;
      st_d.susp    = 1'b0;
      st_d.rst_act = 1'b0;
      st_d.chg     = st_d.chg & 5'b01000;
    end
    if (glb_on)
      st_d.pwr = 1'b1;
    if (bus_rst)
      st_d.chg = 5'b10110;
    if (mark_conn) begin
      if (!st_d.conn)
        st_d.chg[0] = 1'b1;
      st_d.conn = 1'b1;
    end
    if (wb0) begin
      if (wdata[4]) begin
        if (st_d.conn) begin
          st_d.rst_act = 1'b1;
          start        = 1'b1;
        end else begin
          st_d.chg[0] = 1'b1;
        end
      end
      if (wdata[3])
        st_d.susp = 1'b0;
      if (wdata[2])
        st_d.susp = 1'b1;
      if (wdata[3] && st_q.susp && !st_d.susp)
        st_d.chg[2] = 1'b1;
      if (wdata[1]) begin
        if (st_d.conn) st_d.ena = 1'b1;
        else           st_d.chg[0] = 1'b1;
      end
      if (wdata[0]) begin
        if (st_d.conn) st_d.ena = 1'b0;
        else           st_d.chg[0] = 1'b1;
      end
    end
    if (wb1) begin
      if (wdata[9]) begin
        st_d.pwr     = 1'b0;
        st_d.conn    = 1'b0;
        st_d.ena     = 1'b0;
        st_d.susp    = 1'b0;
        st_d.rst_act = 1'b0;
        st_d.chg     = st_d.chg & 5'b01000;
      end
      if (wdata[8])
        st_d.pwr = 1'b1;
    end
    if (wb2)
      st_d.chg = st_d.chg & ~wdata[20:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      pres_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pres_q <= dev_present;
    end
  end

  // R3: the timer only runs while the port is in reset
  p_timer_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_busy |-> st_q.rst_act);

  // R5: an enabled port is always a connected one
  p_enable_connected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.ena |-> st_q.conn);

  // R4: a command needing a device on an empty port flags connect change
  p_empty_cmd_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_q.conn && wb0 && (wdata[4] || wdata[1] || wdata[0])
     && !(be[2] && wdata[16]) && !(wb1 && wdata[9])) |=> st_q.chg[0]);

  // R8: a global power-off leaves the port unpowered
  p_power_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_off && !glb_on && !(wb1 && wdata[8])) |=> !st_q.pwr);
endmodule

// File: rtl/rh_hub_regs.sv
module rh_hub_regs
  import rh_pkg::*;
#(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [1:0]        fstate,
  output logic [1:0]        pmode,
  output logic [NPORTS-1:0] removable,
  output logic [NPORTS-1:0] pmask,
  output logic              hub_b15,
  output logic [NPORTS-1:0] glb_on,
  output logic [NPORTS-1:0] glb_off,
  output logic              bus_rst,
  output logic [NPORTS-1:0] mark_conn,
  output logic [NPORTS-1:0] pwr_ok
);
  logic [1:0]        fstate_q, fstate_d;
  logic [1:0]        pmode_q, pmode_d;
  logic [NPORTS-1:0] rem_q, rem_d;
  logic [NPORTS-1:0] pmask_q, pmask_d;
  logic              b15_q, b15_d;
  logic              w_ctrl, w_desca, w_descb, w_hub;
  logic              all_on, g_on_cmd, g_off_cmd;

  assign w_ctrl  = bus_wr && (bus_addr == ADDR_W'(WORD_CTRL));
  assign w_desca = bus_wr && (bus_addr == ADDR_W'(WORD_DESCA));
  assign w_descb = bus_wr && (bus_addr == ADDR_W'(WORD_DESCB));
  assign w_hub   = bus_wr && (bus_addr == ADDR_W'(WORD_HUB));

  assign all_on    = w_desca && bus_be[1] && bus_wdata[9];
  assign g_on_cmd  = w_hub && bus_be[2] && bus_wdata[16];
  assign g_off_cmd = w_hub && bus_be[0] && bus_wdata[0];
  assign bus_rst   = w_ctrl && bus_be[0] && (bus_wdata[7:6] == 2'b00);

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_port_ctl
      logic follows_glb;
      assign follows_glb  = (pmode_q == 2'd0) || ((pmode_q == 2'd1) && !pmask_q[i]);
      assign glb_on[i]    = (g_on_cmd && follows_glb) || all_on;
      assign glb_off[i]   = g_off_cmd && follows_glb;
      assign mark_conn[i] = w_descb && bus_be[0] && !bus_wdata[1+i];
      assign pwr_ok[i]    = (pmode_q == 2'd1) && pmask_q[i];
    end
  endgenerate

  always_comb begin
    fstate_d = fstate_q;
    pmode_d  = pmode_q;
    rem_d    = rem_q;
    pmask_d  = pmask_q;
    b15_d    = b15_q;
    if (w_ctrl && bus_be[0])
      fstate_d = bus_wdata[7:6];
    if (w_desca && bus_be[1])
      pmode_d = bus_wdata[9:8];
    if (w_descb && bus_be[0])
      rem_d = bus_wdata[NPORTS:1];
    if (w_descb && bus_be[2])
      pmask_d = bus_wdata[16+NPORTS:17];
    if (w_hub && bus_be[1] && bus_wdata[15])
      b15_d = 1'b1;
    if (w_hub && bus_be[3] && bus_wdata[31])
      b15_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fstate_q <= 2'd0;
      pmode_q  <= 2'd0;
      rem_q    <= '0;
      pmask_q  <= '0;
      b15_q    <= 1'b0;
    end else begin
      fstate_q <= fstate_d;
      pmode_q  <= pmode_d;
      rem_q    <= rem_d;
      pmask_q  <= pmask_d;
      b15_q    <= b15_d;
    end
  end

  assign fstate    = fstate_q;
  assign pmode     = pmode_q;
  assign removable = rem_q;
  assign pmask     = pmask_q;
  assign hub_b15   = b15_q;

  // R12: a set of bit 15 without a clear in the same write leaves it set
  p_hub_bit15_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (w_hub && bus_be[1] && bus_wdata[15] && !(bus_be[3] && bus_wdata[31])) |=> hub_b15);
endmodule

// File: rtl/rh_port_block.sv
module rh_port_block
  import rh_pkg::*;
#(
  parameter int unsigned NPORTS      = 2,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned RESET_TICKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              reset_tick,
  input  logic [NPORTS-1:0] dev_present
);
  logic [1:0]        fstate, pmode;
  logic [NPORTS-1:0] removable, pmask, glb_on, glb_off, mark_conn, pwr_ok;
  logic              hub_b15, bus_rst;
  port_state_t       pst [NPORTS];

  rh_hub_regs #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) i_hub (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .fstate    (fstate),
    .pmode     (pmode),
    .removable (removable),
    .pmask     (pmask),
    .hub_b15   (hub_b15),
    .glb_on    (glb_on),
    .glb_off   (glb_off),
    .bus_rst   (bus_rst),
    .mark_conn (mark_conn),
    .pwr_ok    (pwr_ok)
  );

  generate
    for (genvar i = 0; i < NPORTS; i++) begin : g_port
      logic wr_sel;
      assign wr_sel = bus_wr && (bus_addr == ADDR_W'(WORD_PORT0 + i));
      rh_port_unit #(.RESET_TICKS(RESET_TICKS)) i_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_present (dev_present[i]),
        .tick        (reset_tick),
        .wr_sel      (wr_sel),
        .be          (bus_be),
        .wdata       (bus_wdata),
        .glb_on      (glb_on[i]),
        .glb_off     (glb_off[i]),
        .bus_rst     (bus_rst),
        .mark_conn   (mark_conn[i]),
        .pwr_ok      (pwr_ok[i]),
        .st          (pst[i])
      );
    end
  endgenerate

  always_comb begin
    rd_data = 32'h0;
    if (rd_addr == ADDR_W'(WORD_CTRL))
      rd_data[7:6] = fstate;
    else if (rd_addr == ADDR_W'(WORD_DESCA))
      rd_data = {22'h0, pmode, 8'(NPORTS)};
    else if (rd_addr == ADDR_W'(WORD_DESCB)) begin
      rd_data[NPORTS:1]      = removable;
      rd_data[16+NPORTS:17]  = pmask;
    end else if (rd_addr == ADDR_W'(WORD_HUB))
      rd_data[15] = hub_b15;
    else begin
      for (int i = 0; i < NPORTS; i++)
        if (rd_addr == ADDR_W'(WORD_PORT0 + i))
          rd_data = pack_port(pst[i]);
    end
  end
endmodule

// File: tb/test_rh_port_block.sv
module test_rh_port_block;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int TICKS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        reset_tick = 1'b0;
  logic [NP-1:0] dev_present = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rh_port_block #(.NPORTS(NP), .ADDR_W(4), .RESET_TICKS(TICKS)) i_rh_port_block (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .reset_tick(reset_tick), .dev_present(dev_present)
  );

  task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    reset_tick = 1'b1;
    @(negedge clk);
    reset_tick = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s word %0d: actual %08h expected %08h", req, a, rd_data, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 4, 32'h0); chk("R1", 5, 32'h0); chk("R1", 3, 32'h0);
    chk("R1", 1, 32'h00000002);
    // R4 commands on an empty port
    wr(4, 4'b0001, 32'h13);
    chk("R4", 4, 32'h00010000);
    // R7 write-one-to-clear change byte
    wr(4, 4'b0100, 32'h001F0000);
    chk("R7", 4, 32'h0);
    // R2 device attach
    @(negedge clk); dev_present[0] = 1'b1;
    @(negedge clk);
    chk("R2", 4, 32'h00010001); chk("R2", 5, 32'h0);
    // R7 top byte ignored
    wr(4, 4'b1000, 32'hFF000000);
    chk("R7", 4, 32'h00010001);
    wr(4, 4'b0100, 32'h00010000);
    chk("R7", 4, 32'h00000001);
    // R5 enable / disable
    wr(4, 4'b0001, 32'h02); chk("R5", 4, 32'h3);
    wr(4, 4'b0001, 32'h01); chk("R5", 4, 32'h1);
    wr(4, 4'b0001, 32'h03); chk("R5", 4, 32'h1);
    // R6 suspend
    wr(4, 4'b0001, 32'h02);
    wr(4, 4'b0001, 32'h04); chk("R6", 4, 32'h7);
    wr(4, 4'b0001, 32'h0C); chk("R6", 4, 32'h7);
    wr(4, 4'b0001, 32'h08); chk("R6", 4, 32'h00040003);
    wr(4, 4'b0100, 32'h00040000); chk("R6", 4, 32'h3);
    // R3 timed reset
    wr(4, 4'b0001, 32'h10); chk("R3", 4, 32'h13);
    repeat (5) @(negedge clk);
    chk("R3", 4, 32'h13);
    for (int k = 0; k < TICKS - 1; k++) pulse_tick();
    chk("R3", 4, 32'h13);
    pulse_tick();
    chk("R3", 4, 32'h00100003);
    wr(4, 4'b0100, 32'h00100000);
    // R8 global power in mode 0
    wr(3, 4'b0100, 32'h00010000);
    chk("R8", 4, 32'h103); chk("R8", 5, 32'h100);
    wr(3, 4'b0001, 32'h1);
    chk("R8", 4, 32'h0); chk("R8", 5, 32'h0);
    // R10 non-removable marks connected
    wr(2, 4'b0001, 32'h4);
    chk("R10", 4, 32'h00010001); chk("R10", 5, 32'h0); chk("R10", 2, 32'h4);
    wr(4, 4'b0100, 32'h00010000);
    wr(2, 4'b0001, 32'h4);
    chk("R10", 4, 32'h1);
    wr(2, 4'b0001, 32'h6);
    // R9 mode 1 with mask
    wr(1, 4'b0010, 32'h100);
    wr(2, 4'b0100, 32'h00040000);
    chk("R9", 2, 32'h00040006);
    wr(3, 4'b0100, 32'h00010000);
    chk("R9", 4, 32'h101); chk("R9", 5, 32'h0);
    wr(5, 4'b0010, 32'h100); chk("R9", 5, 32'h100);
    wr(4, 4'b0010, 32'h200); chk("R9", 4, 32'h101);
    wr(3, 4'b0001, 32'h1);
    chk("R9", 4, 32'h0); chk("R9", 5, 32'h100);
    wr(5, 4'b0010, 32'h200); chk("R9", 5, 32'h0);
    // R13 power-all through descriptor A
    wr(1, 4'b0010, 32'h200);
    chk("R13", 4, 32'h100); chk("R13", 5, 32'h100); chk("R13", 1, 32'h202);
    // R11 bus reset state loads change byte
    wr(0, 4'b0001, 32'h80);
    chk("R11", 4, 32'h100); chk("R11", 0, 32'h80);
    wr(0, 4'b0001, 32'h00);
    chk("R11", 4, 32'h00160100); chk("R11", 5, 32'h00160100);
    // R12 hub bit 15
    wr(3, 4'b0010, 32'h8000); chk("R12", 3, 32'h8000);
    wr(3, 4'b1000, 32'h80000000); chk("R12", 3, 32'h0);
    // R2 attach and removal on port 1
    @(negedge clk); dev_present[1] = 1'b1;
    @(negedge clk);
    chk("R2", 5, 32'h00170101);
    wr(5, 4'b0001, 32'h02); chk("R2", 5, 32'h00170103);
    @(negedge clk); dev_present[1] = 1'b0;
    @(negedge clk);
    chk("R2", 5, 32'h00170100);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule